// File: doc/BRIEF.md
# 68000 Bus Cycle Bridge

This block turns the strobes of a processor-side asynchronous memory controller into 68000-style bus cycles. It follows the real bus clock: the bus clock input is oversampled in the system clock domain, and each of its rising and falling edges moves the bus-state sequence (S1 to S7) forward by one half-state. The bus state therefore never drifts from the bus latches.

The controller starts a cycle by pulling chip select and one of its strobes low. The bridge drives the data strobes from the byte enables, R/W from the write strobe and the function code from the supervisor and interrupt-acknowledge inputs. It holds a single wait output high until the bus acknowledges the cycle. A bus acknowledge is either DTACK, or VPA followed by a VMA exchange timed against a free-running E clock that the block generates itself.

Top module: `bus68_bridge`

## Requirements
- R1: A cycle starts on a rising bus-clock edge when cs_ni is low and we_ni or oe_ni is low. After a previous start, we_ni and oe_ni must both have been high again before another start is accepted. rw_o and fc_o take the cycle's values from that edge.
- R2: The state advances by one on every bus-clock edge, rising and falling. uds_no and lds_no go low one half-clock after the start, following be_ni[1] and be_ni[0] (0 = lane enabled) captured at the start.
- R3: rw_o equals we_ni captured at the start (0 = write, 1 = read) and stays stable for the whole cycle. It is 1 when idle.
- R4: fc_o is 3'b001 for a user cycle (super_i=0) and 3'b110 for a supervisor cycle. It is 3'b111 when iack_i is high, regardless of super_i. It is 3'b000 when idle.
- R5: dtack_ni and vpa_ni pass through two stages sampled on falling bus-clock edges. The bus-state machine leaves S4 only on a rising edge at which a synchronized acknowledge is present. Otherwise it inserts wait states.
- R6: wait_o is high from the start edge until the acknowledge decision. It is low after that and while idle.
- R7: eclk_o runs freely from reset with a period of 10 bus clocks: low for 6 rising edges, then high for 4.
- R8: If synchronized VPA is present at the S4 decision, it takes precedence over DTACK, which is then ignored. vma_no goes low at the next falling edge of eclk_o. The cycle moves to S7 at the following falling edge of eclk_o.
- R9: uds_no, lds_no and vma_no return high on the falling bus-clock edge that ends S7.
- R10: During reset and just after it, uds_no, lds_no, vma_no and rw_o are high, and fc_o, wait_o and eclk_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Bus clock from the 68000-style bus |
| cs_ni | input | 1 | Controller chip select, active low |
| we_ni | input | 1 | Controller write strobe, active low |
| oe_ni | input | 1 | Controller read strobe, active low |
| be_ni | input | 2 | Byte enables, bit 1 upper, bit 0 lower, active low |
| iack_i | input | 1 | Interrupt-acknowledge select |
| super_i | input | 1 | Supervisor flag |
| dtack_ni | input | 1 | Bus data acknowledge, active low |
| vpa_ni | input | 1 | Bus valid peripheral address, active low |
| uds_no | output | 1 | Upper data strobe, active low |
| lds_no | output | 1 | Lower data strobe, active low |
| rw_o | output | 1 | Read/write, 1 = read |
| fc_o | output | 3 | Function code |
| vma_no | output | 1 | Valid memory address, active low |
| eclk_o | output | 1 | Generated E clock |
| wait_o | output | 1 | Hold request to the controller, active high |

## Verification
The two acknowledges can arrive together. DTACK and VPA can both be present in the synchronizer at the S4 decision edge, and the E clock can fall on the same rising edge at which the cycle enters its peripheral wait. A directed cycle holds both acknowledges low throughout, and the random phase drops VPA in at arbitrary E-clock phases. A reference model stepped once per bus-clock edge checks that the cycle follows the VPA path and ignores DTACK. The same model checks that VMA waits for a later E-clock fall instead of reacting on the edge where the cycle entered that wait.

// File: rtl/bus68_pkg.sv
package bus68_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_S7, ST_PER_A, ST_PER_B
  } bstate_e;

  typedef struct packed {
    logic       rw;
    logic [2:0] fc;
    logic [1:0] be;  // active high lane enables
  } cyc_attr_t;

  localparam logic [2:0] FC_USER = 3'b001;
  localparam logic [2:0] FC_SUPV = 3'b110;
  localparam logic [2:0] FC_IACK = 3'b111;
endpackage

// File: rtl/bclk_edge_det.sv
module bclk_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], bclk_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/bus_in_sync.sv
module bus_in_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic [WIDTH-1:0] din_ni,
  output logic [WIDTH-1:0] dout_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q <= '0;
      else if (fall_i) sh_q <= {sh_q[STAGES-2:0], ~din_ni[b]};
    end
    assign dout_o[b] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/eclk_gen.sv
module eclk_gen #(
  parameter int PERIOD = 10,
  parameter int HIGH   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic eclk_o,
  output logic efall_o
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] HI_AT = CNT_W'(PERIOD - HIGH);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (rise_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign eclk_o  = (cnt_q >= HI_AT);
  assign efall_o = rise_i && (cnt_q == LAST);
endmodule

// File: rtl/bus_fsm.sv
module bus_fsm
  import bus68_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       efall_i,
  input  logic       cs_ni,
  input  logic       we_ni,
  input  logic       oe_ni,
  input  logic [1:0] be_ni,
  input  logic       iack_i,
  input  logic       super_i,
  input  logic       dtack_i,
  input  logic       vpa_i,
  output bstate_e    state_o,
  output logic       uds_no,
  output logic       lds_no,
  output logic       rw_o,
  output logic [2:0] fc_o,
  output logic       vma_no,
  output logic       wait_o
);
  bstate_e   state_q, state_d;
  cyc_attr_t attr_q;
  logic      armed_q, vma_q, start, strobe_on, busy;

  assign start = (state_q == ST_IDLE) && rise_i && armed_q && !cs_ni && (!we_ni || !oe_ni);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)   state_d = ST_S1;
      ST_S1:    if (fall_i)  state_d = ST_S2;
      ST_S2:    if (rise_i)  state_d = ST_S3;
      ST_S3:    if (fall_i)  state_d = ST_S4;
      ST_S4:    if (rise_i) begin
                  if (vpa_i)        state_d = ST_PER_A;  // VPA wins over DTACK
                  else if (dtack_i) state_d = ST_S5;
                end
      ST_S5:    if (fall_i)  state_d = ST_S6;
      ST_S6:    if (rise_i)  state_d = ST_S7;
      ST_S7:    if (fall_i)  state_d = ST_IDLE;
      ST_PER_A: if (efall_i) state_d = ST_PER_B;
      ST_PER_B: if (efall_i) state_d = ST_S7;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      attr_q  <= '{rw: 1'b1, fc: 3'b000, be: 2'b00};
      armed_q <= 1'b1;
      vma_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start)                armed_q <= 1'b0;
      else if (we_ni && oe_ni)  armed_q <= 1'b1;
      if (start) begin
        attr_q.rw <= we_ni;
        attr_q.fc <= iack_i ? FC_IACK : (super_i ? FC_SUPV : FC_USER);
        attr_q.be <= ~be_ni;
      end
      if (state_q == ST_PER_A && efall_i)  vma_q <= 1'b1;
      else if (state_q == ST_S7 && fall_i) vma_q <= 1'b0;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign strobe_on = busy && (state_q != ST_S1);
  assign uds_no    = ~(strobe_on && attr_q.be[1]);
  assign lds_no    = ~(strobe_on && attr_q.be[0]);
  assign rw_o      = busy ? attr_q.rw : 1'b1;
  assign fc_o      = busy ? attr_q.fc : 3'b000;
  assign vma_no    = ~vma_q;
  assign wait_o    = state_q inside {ST_S1, ST_S2, ST_S3, ST_S4, ST_PER_A, ST_PER_B};
  assign state_o   = state_q;
endmodule

// File: rtl/bus68_bridge.sv
module bus68_bridge
  import bus68_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int E_PERIOD    = 10,
  parameter int E_HIGH      = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bclk_i,
  input  logic       cs_ni,
  input  logic       we_ni,
  input  logic       oe_ni,
  input  logic [1:0] be_ni,
  input  logic       iack_i,
  input  logic       super_i,
  input  logic       dtack_ni,
  input  logic       vpa_ni,
  output logic       uds_no,
  output logic       lds_no,
  output logic       rw_o,
  output logic [2:0] fc_o,
  output logic       vma_no,
  output logic       eclk_o,
  output logic       wait_o
);
  logic       bclk_rise, bclk_fall, efall;
  logic [1:0] ack_a;  // [1] VPA, [0] DTACK
  bstate_e    state;

  bclk_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i, .rst_ni, .bclk_i, .rise_o(bclk_rise), .fall_o(bclk_fall)
  );

  bus_in_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_insync (
    .clk_i, .rst_ni, .fall_i(bclk_fall), .din_ni({vpa_ni, dtack_ni}), .dout_o(ack_a)
  );

  eclk_gen #(.PERIOD(E_PERIOD), .HIGH(E_HIGH)) u_eclk (
    .clk_i, .rst_ni, .rise_i(bclk_rise), .eclk_o, .efall_o(efall)
  );

  bus_fsm u_fsm (
    .clk_i, .rst_ni, .rise_i(bclk_rise), .fall_i(bclk_fall), .efall_i(efall),
    .cs_ni, .we_ni, .oe_ni, .be_ni, .iack_i, .super_i,
    .dtack_i(ack_a[0]), .vpa_i(ack_a[1]),
    .state_o(state), .uds_no, .lds_no, .rw_o, .fc_o, .vma_no, .wait_o
  );
endmodule

// File: rtl/bus68_bridge_chk.sv
module bus68_bridge_chk
  import bus68_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rise_i,
  input logic       fall_i,
  input bstate_e    state,
  input logic       uds_no,
  input logic       lds_no,
  input logic       rw_o,
  input logic [2:0] fc_o,
  input logic       vma_no,
  input logic       eclk_o,
  input logic       wait_o
);
  p_state_on_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != $past(state)) |-> $past(rise_i || fall_i));

  p_attr_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(rw_o) && $stable(fc_o)));

  p_fc_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fc_o inside {3'b000, 3'b001, 3'b110, 3'b111});

  p_wait_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wait_o) |-> (state == ST_S5 || state == ST_S7));

  p_vma_on_efall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vma_no) |-> $fell(eclk_o));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (vma_no && uds_no && lds_no));
endmodule

bind bus68_bridge bus68_bridge_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(bclk_rise), .fall_i(bclk_fall),
  .state(state), .uds_no(uds_no), .lds_no(lds_no), .rw_o(rw_o), .fc_o(fc_o),
  .vma_no(vma_no), .eclk_o(eclk_o), .wait_o(wait_o)
);

// File: tb/tb_bus68_bridge.sv
module tb_bus68_bridge;
  logic       clk_i = 1'b0, rst_ni = 1'b0, bclk_i = 1'b0;
  logic       cs_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, iack_i = 1'b0, super_i = 1'b0;
  logic       dtack_ni = 1'b1, vpa_ni = 1'b1;
  logic [1:0] be_ni = 2'b11;
  logic       uds_no, lds_no, rw_o, vma_no, eclk_o, wait_o;
  logic [2:0] fc_o;

  int n_checks = 0, n_errors = 0;

  // reference model state (0 idle, 1..7 = S1..S7, 8/9 = peripheral waits)
  int         m_st = 0, m_ecnt = 0;
  bit         m_armed = 1, m_vma = 0, m_rw = 1;
  bit   [2:0] m_fc = 0;
  bit   [1:0] m_be = 0, m_ds = 0, m_vs = 0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  bus68_bridge dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [2:0] exp_fc(input bit iack, input bit sup);
    return iack ? 3'b111 : (sup ? 3'b110 : 3'b001);  // R4
  endfunction

  task automatic model_step(input bit rise);
    bit efall;
    efall = rise && (m_ecnt == 9);
    if (we_ni && oe_ni) m_armed = 1;
    case (m_st)
      0: if (rise && m_armed && !cs_ni && (!we_ni || !oe_ni)) begin
           m_st = 1; m_armed = 0; m_rw = we_ni; m_fc = exp_fc(iack_i, super_i); m_be = ~be_ni;
         end
      1: if (!rise) m_st = 2;
      2: if (rise)  m_st = 3;
      3: if (!rise) m_st = 4;
      4: if (rise) begin
           if (m_vs[1]) m_st = 8;
           else if (m_ds[1]) m_st = 5;
         end
      5: if (!rise) m_st = 6;
      6: if (rise)  m_st = 7;
      7: if (!rise) begin m_st = 0; m_vma = 0; end
      8: if (efall) begin m_st = 9; m_vma = 1; end
      9: if (efall) m_st = 7;
      default: m_st = 0;
    endcase
    if (!rise) begin
      m_ds = {m_ds[0], ~dtack_ni};
      m_vs = {m_vs[0], ~vpa_ni};
    end
    if (rise) m_ecnt = (m_ecnt == 9) ? 0 : m_ecnt + 1;
  endtask

  task automatic compare();
    bit busy, strb, wt;
    busy = (m_st != 0);
    strb = (m_st >= 2);
    wt   = (m_st inside {1, 2, 3, 4, 8, 9});
    chk("R2 R9 uds", uds_no, !(strb && m_be[1]));
    chk("R2 R9 lds", lds_no, !(strb && m_be[0]));
    chk("R1 R3 rw", rw_o, busy ? m_rw : 1'b1);
    chk("R1 R4 fc", fc_o, busy ? m_fc : 3'b000);
    chk("R5 R6 wait", wait_o, wt);
    chk("R7 eclk", eclk_o, m_ecnt >= 6);
    chk("R8 R9 vma", vma_no, !m_vma);
  endtask

  // one bus-clock edge: inputs change with the edge, sample 4 system clocks later
  task automatic step();
    bclk_i = ~bclk_i;
    repeat (4) @(negedge clk_i);
    model_step(bclk_i);
    compare();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk_i);
    // R10 reset state
    chk("R10 uds", uds_no, 1); chk("R10 lds", lds_no, 1); chk("R10 vma", vma_no, 1);
    chk("R10 rw", rw_o, 1); chk("R10 fc", fc_o, 0); chk("R10 wait", wait_o, 0);
    chk("R10 eclk", eclk_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk("R10 post-reset wait", wait_o, 0);

    // directed: user read, DTACK at once (R1 R2 R5)
    cs_ni = 0; oe_ni = 0; be_ni = 2'b00; dtack_ni = 0;
    for (int i = 0; i < 16; i++) step();
    oe_ni = 1; dtack_ni = 1;
    for (int i = 0; i < 4; i++) step();

    // directed: supervisor write to upper lane, DTACK late -> wait states (R5)
    we_ni = 0; super_i = 1; be_ni = 2'b01;
    for (int i = 0; i < 14; i++) step();
    dtack_ni = 0;
    for (int i = 0; i < 10; i++) step();
    we_ni = 1; dtack_ni = 1; super_i = 0;
    for (int i = 0; i < 4; i++) step();

    // directed: DTACK and VPA together -> VPA path, DTACK ignored (R8)
    oe_ni = 0; iack_i = 1; dtack_ni = 0; vpa_ni = 0; be_ni = 2'b10;
    for (int i = 0; i < 60; i++) step();
    chk("R8 both-ack cycle finished", wait_o, 0);
    oe_ni = 1; iack_i = 0; dtack_ni = 1; vpa_ni = 1;
    for (int i = 0; i < 4; i++) step();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      if (we_ni && oe_ni) begin
        if ($urandom % 3 == 0) begin
          if ($urandom % 2) we_ni = 0; else oe_ni = 0;
          be_ni   = 2'($urandom);
          super_i = 1'($urandom);
          iack_i  = ($urandom % 6 == 0);
          cs_ni   = ($urandom % 8 == 0);
        end
      end else if ($urandom % 10 == 0) begin
        we_ni = 1; oe_ni = 1;
      end
      if ($urandom % 4 == 0) dtack_ni = ~dtack_ni;
      if ($urandom % 5 == 0) vpa_ni = ($urandom % 10 != 0);
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(3_000_000);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule